// File: doc/BRIEF.md
# Two-Lane Multiply-Accumulate FIR Filter

This block is a 256-tap finite impulse response filter for a slow sample stream. Each accepted input sample goes into a 256-entry history held in a dual-port RAM. The RAM works as a circular buffer: a write pointer advances by one place per sample, so older samples never have to be moved. When a sample is accepted, the filter computes one output. Two multiply-accumulate lanes run side by side. Lane 0 walks taps 0 to 127 and lane 1 walks taps 128 to 255, one tap each per cycle. A final three-input adder merges both products into a running sum.

The coefficient store holds four coefficient sets. A 2-bit select input chooses the set for each computation, and the select is captured when the sample is accepted. The result is a 44-bit signed value, wide enough for the full bit growth of an 18-bit by 18-bit product summed 256 times. It is presented with a single-cycle valid pulse and then held until the next result.

Top module: `fir_ps`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is 0 and `result_o` is 0 until the first result is produced.
- R2: A sample is accepted on a rising clock edge where `valid_i` is 1 and no computation is in progress. The result for that sample appears on `result_o`, with `valid_o` high, exactly 130 cycles after the accepting edge (TAPS/2 + 2). The filter can accept the next sample on the edge that directly follows the `valid_o` cycle.
- R3: The result equals the sum over k = 0..255 of h[s][k] * x[k]. Here x[0] is the sample just accepted, x[k] is the sample accepted k acceptances earlier, and s is the captured select.
- R4: Every history position that has not yet received a sample since reset contributes zero.
- R5: The history holds at most 256 samples. Once 257 or more samples have been accepted, the oldest ones no longer contribute.
- R6: The coefficient address is {select, tap}, so `sel_i` picks one of four sets. `sel_i` is sampled only on the accepting edge, and changes to it during a computation do not affect the result.
- R7: The coefficient h[s][k] is 18-bit signed, defined per set as follows:
  - set 0: h = 1 for every tap.
  - set 1: h = k - 128.
  - set 2: h = 131071 at k = 0 and 0 elsewhere.
  - set 3: h = 131071 at even k and -131072 at odd k.
- R8: A `valid_i` that arrives while a computation is in progress is ignored. Its sample is not stored, and the results that follow are unchanged.
- R9: `result_o` holds its value between `valid_o` pulses. It is exact for full-scale inputs with set 3, with no overflow.
- R10: `valid_o` is high for exactly one cycle per accepted sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe; starts a computation when idle |
| sample_i | input | 18 | Signed input sample |
| sel_i | input | 2 | Coefficient set select, captured on acceptance |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | 44 | Signed filter output, held between strobes |

## Verification
Two situations are hard to reach from the ports. The first is a `valid_i` that lands on the very edge where a computation finishes, or on the edge just after it. This decides whether a sample is ignored or accepted. The bench reaches it by holding `valid_i` high for hundreds of cycles while the sample value changes every cycle, so acceptance happens exactly at each idle boundary. The second is the wrap of the circular history combined with worst-case bit growth. The bench reaches it by streaming more than 256 alternating full-scale samples through set 3, and by sending out-of-turn strobes with a changed select in the middle of computations.

// File: rtl/fir_ps_pkg.sv
package fir_ps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } fir_state_e;
endpackage

// File: rtl/fir_ps_sample_ram.sv
module fir_ps_sample_ram #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic signed [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]            raddr_a_i,
  input  logic [AW-1:0]            raddr_b_i,
  output logic signed [DATA_W-1:0] rdata_a_o,
  output logic signed [DATA_W-1:0] rdata_b_o
);
  logic signed [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/fir_ps_coef_rom.sv
module fir_ps_coef_rom #(
  parameter int COEF_W = 18,
  parameter int TAPS   = 256,
  parameter int SETS   = 4,
  localparam int KW    = $clog2(TAPS),
  localparam int SW    = $clog2(SETS),
  localparam int AW    = KW + SW
) (
  input  logic                     clk_i,
  input  logic [AW-1:0]            addr_a_i,
  input  logic [AW-1:0]            addr_b_i,
  output logic signed [COEF_W-1:0] data_a_o,
  output logic signed [COEF_W-1:0] data_b_o
);
  localparam logic signed [COEF_W-1:0] POS_FS = {1'b0, {(COEF_W-1){1'b1}}};
  localparam logic signed [COEF_W-1:0] NEG_FS = {1'b1, {(COEF_W-1){1'b0}}};

  function automatic logic signed [COEF_W-1:0] coef_at(input logic [AW-1:0] a);
    logic [SW-1:0] set;
    logic [KW-1:0] k;
    logic signed [COEF_W-1:0] v;
    set = a[AW-1 -: SW];
    k   = a[KW-1:0];
    case (2'(set))
      2'd0:    v = COEF_W'(1);
      2'd1:    v = COEF_W'(k) - COEF_W'(TAPS / 2);
      2'd2:    v = (k == '0) ? POS_FS : '0;
      default: v = k[0] ? NEG_FS : POS_FS;
    endcase
    return v;
  endfunction

  // registered read, one coefficient per port per cycle
  always_ff @(posedge clk_i) begin
    data_a_o <= coef_at(addr_a_i);
    data_b_o <= coef_at(addr_b_i);
  end
endmodule

// File: rtl/fir_ps_mac_lane.sv
module fir_ps_mac_lane #(
  parameter int DATA_W = 18,
  parameter int COEF_W = 18,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic                     tap_ok_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [PROD_W-1:0] prod_o
);
  logic signed [DATA_W-1:0] sample_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= '0;
      prod_o   <= '0;
    end else begin
      sample_q <= tap_ok_i ? sample_i : '0;
      prod_o   <= PROD_W'(sample_q) * PROD_W'(coef_i);
    end
  end
endmodule

// File: rtl/fir_ps_ctrl.sv
module fir_ps_ctrl
  import fir_ps_pkg::*;
#(
  parameter int TAPS = 256,
  parameter int SETS = 4,
  localparam int HALF  = TAPS / 2,
  localparam int IW    = $clog2(HALF),
  localparam int KW    = $clog2(TAPS),
  localparam int SW    = $clog2(SETS),
  localparam int FW    = KW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SW-1:0]    sel_i,
  output logic             start_o,
  output logic [KW-1:0]    waddr_o,
  output logic [KW-1:0]    raddr_a_o,
  output logic [KW-1:0]    raddr_b_o,
  output logic             tap_ok_a_o,
  output logic             tap_ok_b_o,
  output logic [KW+SW-1:0] rom_a_o,
  output logic [KW+SW-1:0] rom_b_o,
  output logic             acc_en_o,
  output logic             acc_last_o
);
  fir_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic [KW-1:0] wr_ptr_q, head_q;
  logic [FW-1:0] fill_q;
  logic [SW-1:0] sel_q;
  logic          v1_q, last1_q, v2_q, last2_q;
  logic          issue, issue_last;
  logic [KW-1:0] tap_a, tap_b;

  assign start_o    = valid_i && (state_q == ST_IDLE);
  assign issue      = (state_q == ST_ISSUE);
  assign issue_last = issue && (idx_q == IW'(HALF - 1));

  assign tap_a = KW'(idx_q);
  assign tap_b = KW'(idx_q) + KW'(HALF);

  assign waddr_o    = wr_ptr_q;
  assign raddr_a_o  = head_q - tap_a;
  assign raddr_b_o  = head_q - tap_b;
  assign tap_ok_a_o = issue && (FW'(tap_a) < fill_q);
  assign tap_ok_b_o = issue && (FW'(tap_b) < fill_q);
  assign rom_a_o    = {sel_q, tap_a};
  assign rom_b_o    = {sel_q, tap_b};
  assign acc_en_o   = v2_q;
  assign acc_last_o = last2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      wr_ptr_q <= '0;
      head_q   <= '0;
      fill_q   <= '0;
      sel_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_o) begin
          head_q   <= wr_ptr_q;
          wr_ptr_q <= wr_ptr_q + KW'(1);
          if (fill_q != FW'(TAPS)) fill_q <= fill_q + FW'(1);
          sel_q    <= sel_i;
          idx_q    <= '0;
          state_q  <= ST_ISSUE;
        end
        ST_ISSUE: begin
          idx_q <= idx_q + IW'(1);
          if (issue_last) state_q <= ST_DRAIN;
        end
        default: if (last2_q) state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0; last1_q <= 1'b0; v2_q <= 1'b0; last2_q <= 1'b0;
    end else begin
      v1_q    <= issue;
      last1_q <= issue_last;
      v2_q    <= v1_q;
      last2_q <= last1_q;
    end
  end

  assert_ignore_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_q != ST_IDLE) |=> ($stable(wr_ptr_q) && $stable(fill_q)));

  assert_sel_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q == ST_IDLE || $stable(sel_q)));

  assert_fill_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q <= FW'(TAPS)) && (fill_q >= $past(fill_q)));
endmodule

// File: rtl/fir_ps.sv
module fir_ps #(
  parameter int DATA_W = 18,
  parameter int COEF_W = 18,
  parameter int TAPS   = 256,
  parameter int SETS   = 4,
  parameter int ACC_W  = 44,
  localparam int KW     = $clog2(TAPS),
  localparam int SW     = $clog2(SETS),
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic [SW-1:0]           sel_i,
  output logic                    valid_o,
  output logic signed [ACC_W-1:0] result_o
);
  logic             start, acc_en, acc_last;
  logic [KW-1:0]    waddr;
  logic [KW-1:0]    raddr [2];
  logic             tap_ok [2];
  logic [KW+SW-1:0] rom_addr [2];
  logic signed [DATA_W-1:0] smp [2];
  logic signed [COEF_W-1:0] coef [2];
  logic signed [PROD_W-1:0] prod [2];
  logic signed [ACC_W-1:0]  acc_q, acc_nxt;

  fir_ps_ctrl #(.TAPS(TAPS), .SETS(SETS)) u_ctrl (
    .clk_i, .rst_ni, .valid_i, .sel_i,
    .start_o(start), .waddr_o(waddr),
    .raddr_a_o(raddr[0]), .raddr_b_o(raddr[1]),
    .tap_ok_a_o(tap_ok[0]), .tap_ok_b_o(tap_ok[1]),
    .rom_a_o(rom_addr[0]), .rom_b_o(rom_addr[1]),
    .acc_en_o(acc_en), .acc_last_o(acc_last)
  );

  fir_ps_sample_ram #(.DATA_W(DATA_W), .DEPTH(TAPS)) u_ram (
    .clk_i, .we_i(start), .waddr_i(waddr), .wdata_i(sample_i),
    .raddr_a_i(raddr[0]), .raddr_b_i(raddr[1]),
    .rdata_a_o(smp[0]), .rdata_b_o(smp[1])
  );

  fir_ps_coef_rom #(.COEF_W(COEF_W), .TAPS(TAPS), .SETS(SETS)) u_rom (
    .clk_i, .addr_a_i(rom_addr[0]), .addr_b_i(rom_addr[1]),
    .data_a_o(coef[0]), .data_b_o(coef[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    fir_ps_mac_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_lane (
      .clk_i, .rst_ni, .sample_i(smp[g]), .tap_ok_i(tap_ok[g]),
      .coef_i(coef[g]), .prod_o(prod[g])
    );
  end

  // three-input merge: running sum plus both lane products
  assign acc_nxt = acc_q + ACC_W'(prod[0]) + ACC_W'(prod[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= 1'b0;
      if (start) acc_q <= '0;
      else if (acc_en) acc_q <= acc_nxt;
      if (acc_en && acc_last) begin
        result_o <= acc_nxt;
        valid_o  <= 1'b1;
      end
    end
  end

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));

  assert_no_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en |-> !start);
endmodule

// File: tb/fir_ps_bench.sv
module fir_ps_bench;
  localparam int TAPS = 256;
  localparam int LAT  = TAPS / 2 + 2;
  localparam int WD   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic signed [17:0] sample_i = '0;
  logic [1:0] sel_i = '0;
  logic valid_o;
  logic signed [43:0] result_o;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  int     hist[$];
  int     m_cnt = 0;
  bit     exp_v = 1'b0;
  longint exp_y = 0;
  longint pending = 0;
  bit     done = 1'b0;

  always #5 clk = ~clk;

  fir_ps u_fir_ps (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sample_i(sample_i),
    .sel_i(sel_i), .valid_o(valid_o), .result_o(result_o)
  );

  // R7 coefficient sets
  function automatic longint h(int s, int k);
    case (s)
      0: return 1;
      1: return longint'(k - 128);
      2: return (k == 0) ? 131071 : 0;
      default: return (k % 2 == 0) ? 131071 : -131072;
    endcase
  endfunction

  // R3/R4/R5: sum over stored history, newest first, missing entries are zero
  function automatic longint model_sum(int s);
    longint acc = 0;
    for (int k = 0; k < hist.size(); k++) acc += h(s, k) * longint'(hist[k]);
    return acc;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; exp_v = 1'b0; exp_y = 0; hist.delete();
    end else begin
      bit was_busy;
      was_busy = (m_cnt != 0);
      exp_v = 1'b0;
      if (m_cnt != 0) begin
        m_cnt--;
        if (m_cnt == 0) begin exp_v = 1'b1; exp_y = pending; end
      end
      if (valid_i && !was_busy) begin   // R2 accept, R8 ignore when busy
        hist.push_front(int'(sample_i));
        if (hist.size() > TAPS) void'(hist.pop_back());
        pending = model_sum(int'(sel_i));
        m_cnt = LAT;
      end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(valid_o == exp_v, (phase == "R1") ? "R10" : phase, "valid_o R2/R10",
            longint'(valid_o), longint'(exp_v));
      check(longint'(result_o) == exp_y, phase, "result_o R3/R9",
            longint'(result_o), exp_y);
    end
  end

  task automatic send(int x, int s);
    while (m_cnt != 0) @(negedge clk);
    sel_i = 2'(s); sample_i = 18'(x); valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic poke(int x, int s, int dly);
    repeat (dly) @(negedge clk);
    sel_i = 2'(s); sample_i = 18'(x); valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  function automatic int rnd18();
    return int'($urandom % 262144) - 131072;
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(valid_o == 1'b0, "R1", "valid_o in reset", longint'(valid_o), 0);
    check(result_o == '0, "R1", "result_o in reset", longint'(result_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: partially filled history, set 0 and set 1
    phase = "R4";
    send(5, 0); send(-7, 0); send(1000, 1); send(-131072, 1); send(131071, 0);

    // R6/R8: mid-computation select change and ignored strobes
    phase = "R6";
    for (int i = 0; i < 20; i++) begin
      send(rnd18(), 1);
      poke(rnd18(), 3, 5 + i);
      poke(rnd18(), 2, 60);
      sel_i = 2'd0;
    end

    // R7: set 2 passes the newest sample scaled
    phase = "R7";
    for (int i = 0; i < 8; i++) send(rnd18(), 2);

    // R2/R8: valid held high, acceptance only at idle boundaries
    phase = "R2";
    while (m_cnt != 0) @(negedge clk);
    valid_i = 1'b1;
    for (int i = 0; i < 600; i++) begin
      sample_i = 18'(rnd18());
      sel_i = 2'(i % 4);
      @(negedge clk);
    end
    valid_i = 1'b0;

    // R5/R9: wrap past 256 entries with full-scale alternating data, set 3
    phase = "R5";
    for (int i = 0; i < 270; i++) send((i % 2 == 0) ? -131072 : 131071, 3);
    phase = "R9";
    for (int s = 0; s < 4; s++) send(rnd18(), s);
    for (int i = 0; i < 4; i++) send(131071, 3);

    while (m_cnt != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (WD) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule